// File: doc/BRIEF.md
# Receive Character Queue with Error Reporting and Request-to-Send Control

This block is the receive side of one serial channel, starting where a character has already been assembled. A small queue, three characters deep by default, holds each character with its own framing-error, parity-error and break flags. Software reads the oldest character through a data register, reads the queue's state and error summary through a status register, and programs behaviour through a pair of mode registers. Both mode registers sit behind one address and are reached through a pointer that moves forward by itself.

Error reporting has two modes. Per-character mode shows the flags of the character at the head of the queue. Accumulating mode shows the OR of the flags of every character that has reached the head since software last issued the clear-errors command. The receiver interrupt line follows either "queue not empty" or "queue full", as selected by a mode bit. The active-low request-to-send output normally follows a bit that software writes. When automatic flow control is enabled, a start bit detected while the queue is full forces the output inactive. The software bit stays as it was, so the output becomes active again as soon as a slot frees up.

Top module: `rx_char_queue`

## Requirements
- R1: After reset the queue is empty, the pointer selects mode register 1, both mode registers and the software request bit are 0, rtsN is 1, rxIrq is 0 and the status register reads 0.
- R2: Characters leave in arrival order. The queue holds DEPTH characters. A read of address 1 returns the head character and removes it, and status bit 0 (not empty) and bit 1 (full) track the occupancy.
- R3: A character that arrives while the queue is full, with no removal in the same cycle, is discarded and sets the overrun flag (status bit 2). The clear-errors command clears that flag. An arrival and a removal in the same cycle on a full queue both take effect and do not set overrun.
- R4: Address 0 reaches mode register 1 after reset or after the set-pointer command. Any read or write of mode register 1 moves the pointer to mode register 2, and later accesses stay on mode register 2.
- R5: If mode register 1 bit 6 is 0, rxIrq equals "queue not empty". If it is 1, rxIrq equals "queue full".
- R6: If mode register 1 bit 5 is 0, status bits 3 (parity), 4 (framing) and 5 (break) give the head character's flags, and they read 0 when the queue is empty.
- R7: If mode register 1 bit 5 is 1, status bits 5:3 are the OR of the flags of every character that has reached the head since the last clear-errors command. The value holds after the queue drains, and clear-errors returns it to 0.
- R8: Outside automatic negation, rtsN is the inverse of the software request bit, which is written and read as bit 0 of address 3.
- R9: If mode register 1 bit 7 is 1 and startDet pulses while the queue is full, rtsN is 1 from the next cycle. The software request bit still reads back unchanged.
- R10: Automatic negation ends as soon as the queue is no longer full, and rtsN returns to follow the software bit.
- R11: If mode register 1 bit 7 is 0, or the queue is not full, startDet has no effect on rtsN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| charValid | input | 1 | One-cycle strobe: an assembled character is presented |
| charData | input | DATA_W | Character value |
| charFe | input | 1 | Framing-error flag of the character |
| charPe | input | 1 | Parity-error flag of the character |
| charBrk | input | 1 | Break flag of the character |
| startDet | input | 1 | One-cycle strobe: a valid start bit was detected |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe (side effects at the clock edge) |
| regAddr | input | 2 | 0 mode pair, 1 receive data, 2 status, 3 output control |
| wrData | input | 8 | Write data |
| readData | output | 8 | Combinational read data for regAddr |
| cmdSetPtr | input | 1 | Command: point address 0 at mode register 1 |
| cmdRstErr | input | 1 | Command: clear accumulated errors and overrun |
| rxIrq | output | 1 | Receiver interrupt request |
| rtsN | output | 1 | Active-low request-to-send |

## Verification
The assertions assume that every strobe lasts one cycle and is sampled at the rising edge, and that charValid is never raised with a removal on an empty queue in a way that depends on ordering. The bench drives every input just after a falling edge and holds it through exactly one rising edge. The assertions also assume the clear-errors command does not coincide with an overrun event. The bench issues commands only in cycles with no character arriving. Reads of the status and output-control addresses are made with regRd held low, so they cannot remove a character by accident.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  typedef struct packed {
    logic brk;
    logic fe;
    logic pe;
  } errFlags_t;

  typedef struct packed {
    logic push;
    logic pop;
    logic clrErr;
  } pathCtl_t;

  localparam logic [1:0] ADDR_MODE   = 2'd0;
  localparam logic [1:0] ADDR_DATA   = 2'd1;
  localparam logic [1:0] ADDR_STATUS = 2'd2;
  localparam logic [1:0] ADDR_OUTCTL = 2'd3;

endpackage

// File: rtl/rxq_path.sv
module rxq_path
  import rxq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  pathCtl_t          ctl,
  input  logic              blockMode,
  input  logic [DATA_W-1:0] inData,
  input  errFlags_t         inFlags,
  output logic [DATA_W-1:0] headData,
  output errFlags_t         errStatus,
  output logic              notEmpty,
  output logic              isFull,
  output logic              overrun
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT  = CNT_W'(DEPTH);

  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [CNT_W-1:0]  count;
  logic [DATA_W-1:0] dataVec [DEPTH];
  errFlags_t         flagVec [DEPTH];
  errFlags_t         accum, headFlags, headView;
  logic              doPush, doPop, ovEvent;

  function automatic logic [PTR_W-1:0] stepPtr(input logic [PTR_W-1:0] p);
    return (p == LAST_SLOT) ? '0 : p + 1'b1;
  endfunction

  assign notEmpty = (count != '0);
  assign isFull   = (count == FULL_CNT);
  assign doPop    = ctl.pop && notEmpty;
  assign doPush   = ctl.push && (!isFull || doPop);
  assign ovEvent  = ctl.push && isFull && !doPop;

  for (genvar s = 0; s < DEPTH; s++) begin : g_slot
    logic [DATA_W-1:0] slotData;
    errFlags_t         slotFlags;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slotData  <= '0;
        slotFlags <= '0;
      end else if (doPush && wrPtr == PTR_W'(s)) begin
        slotData  <= inData;
        slotFlags <= inFlags;
      end
    end
    assign dataVec[s] = slotData;
    assign flagVec[s] = slotFlags;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= stepPtr(wrPtr);
      if (doPop)  rdPtr <= stepPtr(rdPtr);
      case ({doPush, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      overrun <= 1'b0;
      accum   <= '0;
    end else begin
      overrun <= (overrun && !ctl.clrErr) || ovEvent;
      if (ctl.clrErr)  accum <= '0;
      else if (doPop)  accum <= accum | headFlags;
    end
  end

  assign headData  = dataVec[rdPtr];
  assign headFlags = flagVec[rdPtr];
  assign headView  = notEmpty ? headFlags : '0;
  assign errStatus = blockMode ? (accum | headView) : headView;

  p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL_CNT);

  p_overrun_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.push && isFull && !ctl.pop) |=> overrun);

  p_discard_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.push && isFull && !ctl.pop) |=> isFull);

  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.clrErr && !(ctl.push && isFull && !ctl.pop)) |=> !overrun);

  p_empty_clean_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!blockMode && !notEmpty) |-> (errStatus == '0));

endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
  import rxq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int REG_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [1:0]        regAddr,
  input  logic [REG_W-1:0]  wrData,
  input  logic              cmdSetPtr,
  input  logic              cmdRstErr,
  input  logic              charValid,
  input  logic              startDet,
  input  logic [DATA_W-1:0] headData,
  input  errFlags_t         errStatus,
  input  logic              notEmpty,
  input  logic              isFull,
  input  logic              overrun,
  output pathCtl_t          ctl,
  output logic              blockMode,
  output logic [REG_W-1:0]  readData,
  output logic              rxIrq,
  output logic              rtsN
);

  localparam int AUTO_RTS_BIT = 7;
  localparam int IRQ_SEL_BIT  = 6;
  localparam int BLOCK_BIT    = 5;

  logic [REG_W-1:0] modeOne, modeTwo, headExt;
  logic             ptrAtTwo, swRts, autoHold, modeAcc, autoNeg;

  assign modeAcc   = (regWr || regRd) && (regAddr == ADDR_MODE);
  assign blockMode = modeOne[BLOCK_BIT];

  assign ctl.push   = charValid;
  assign ctl.pop    = regRd && (regAddr == ADDR_DATA);
  assign ctl.clrErr = cmdRstErr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptrAtTwo <= 1'b0;
      modeOne  <= '0;
      modeTwo  <= '0;
      swRts    <= 1'b0;
    end else begin
      if (regWr && regAddr == ADDR_MODE) begin
        if (ptrAtTwo) modeTwo <= wrData;
        else          modeOne <= wrData;
      end
      if (cmdSetPtr)    ptrAtTwo <= 1'b0;
      else if (modeAcc) ptrAtTwo <= 1'b1;
      if (regWr && regAddr == ADDR_OUTCTL) swRts <= wrData[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                 autoHold <= 1'b0;
    else if (!isFull)                           autoHold <= 1'b0;
    else if (modeOne[AUTO_RTS_BIT] && startDet) autoHold <= 1'b1;
  end

  assign autoNeg = autoHold && isFull;
  assign rtsN    = !(swRts && !autoNeg);
  assign rxIrq   = modeOne[IRQ_SEL_BIT] ? isFull : notEmpty;

  always_comb begin
    headExt = '0;
    headExt[DATA_W-1:0] = headData;
  end

  always_comb begin
    readData = '0;
    case (regAddr)
      ADDR_MODE:   readData = ptrAtTwo ? modeTwo : modeOne;
      ADDR_DATA:   readData = notEmpty ? headExt : '0;
      ADDR_STATUS: readData[5:0] = {errStatus.brk, errStatus.fe, errStatus.pe,
                                    overrun, isFull, notEmpty};
      default:     readData[0] = swRts;
    endcase
  end

  p_ptr_home_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmdSetPtr |=> !ptrAtTwo);

  p_ptr_adv_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (modeAcc && !cmdSetPtr) |=> ptrAtTwo);

  p_rts_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !isFull |-> (rtsN == !swRts));

  p_rts_auto_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (modeOne[AUTO_RTS_BIT] && startDet && isFull && !ctl.pop && !charValid) |=> rtsN);

  p_sw_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (startDet && !(regWr && regAddr == ADDR_OUTCTL)) |=> $stable(swRts));

endmodule

// File: rtl/rx_char_queue.sv
module rx_char_queue
  import rxq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              charValid,
  input  logic [DATA_W-1:0] charData,
  input  logic              charFe,
  input  logic              charPe,
  input  logic              charBrk,
  input  logic              startDet,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [1:0]        regAddr,
  input  logic [7:0]        wrData,
  output logic [7:0]        readData,
  input  logic              cmdSetPtr,
  input  logic              cmdRstErr,
  output logic              rxIrq,
  output logic              rtsN
);

  pathCtl_t          ctl;
  errFlags_t         inFlags, errStatus;
  logic [DATA_W-1:0] headData;
  logic              blockMode, notEmpty, isFull, overrun;

  assign inFlags = '{brk: charBrk, fe: charFe, pe: charPe};

  rxq_path #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_path (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .blockMode(blockMode),
    .inData(charData), .inFlags(inFlags), .headData(headData),
    .errStatus(errStatus), .notEmpty(notEmpty), .isFull(isFull),
    .overrun(overrun)
  );

  rxq_ctrl #(.DATA_W(DATA_W), .REG_W(8)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .regWr(regWr), .regRd(regRd),
    .regAddr(regAddr), .wrData(wrData), .cmdSetPtr(cmdSetPtr),
    .cmdRstErr(cmdRstErr), .charValid(charValid), .startDet(startDet),
    .headData(headData), .errStatus(errStatus), .notEmpty(notEmpty),
    .isFull(isFull), .overrun(overrun), .ctl(ctl), .blockMode(blockMode),
    .readData(readData), .rxIrq(rxIrq), .rtsN(rtsN)
  );

endmodule

// File: tb/rx_char_queue_test.sv
`timescale 1ns/1ps
module rx_char_queue_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic charValid = 1'b0, charFe = 1'b0, charPe = 1'b0, charBrk = 1'b0;
  logic [7:0] charData = '0;
  logic startDet = 1'b0, regWr = 1'b0, regRd = 1'b0;
  logic [1:0] regAddr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] readData;
  logic cmdSetPtr = 1'b0, cmdRstErr = 1'b0;
  logic rxIrq, rtsN;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  rx_char_queue uut (
    .clk(clk), .rst_n(rst_n), .charValid(charValid), .charData(charData),
    .charFe(charFe), .charPe(charPe), .charBrk(charBrk), .startDet(startDet),
    .regWr(regWr), .regRd(regRd), .regAddr(regAddr), .wrData(wrData),
    .readData(readData), .cmdSetPtr(cmdSetPtr), .cmdRstErr(cmdRstErr),
    .rxIrq(rxIrq), .rtsN(rtsN)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pushChar(input logic [7:0] d, input int f);
    charValid = 1'b1; charData = d;
    charPe = f[0]; charFe = f[1]; charBrk = f[2];
    @(negedge clk);
    charValid = 1'b0; charPe = 1'b0; charFe = 1'b0; charBrk = 1'b0;
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [7:0] d);
    regWr = 1'b1; regAddr = a; wrData = d;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic regRead(input logic [1:0] a, output int v);
    regRd = 1'b1; regAddr = a;
    #1 v = readData;
    @(negedge clk);
    regRd = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output int v);
    regAddr = a;
    #1 v = readData;
  endtask

  task automatic setPtr();
    cmdSetPtr = 1'b1; @(negedge clk); cmdSetPtr = 1'b0;
  endtask

  task automatic rstErr();
    cmdRstErr = 1'b1; @(negedge clk); cmdRstErr = 1'b0;
  endtask

  task automatic setMode(input logic [7:0] m);
    setPtr();
    regWrite(2'd0, m);
  endtask

  task automatic pulseStart();
    startDet = 1'b1; @(negedge clk); startDet = 1'b0;
  endtask

  task automatic drain();
    int v;
    for (int i = 0; i < 4; i++) regRead(2'd1, v);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    peek(2'd2, v); chk("R1 status", v, 0);
    peek(2'd0, v); chk("R1 mode1", v, 0);
    peek(2'd3, v); chk("R1 swbit", v, 0);
    chk("R1 rtsN", rtsN, 1);
    chk("R1 irq", rxIrq, 0);

    // R4 pointer walk
    setPtr();
    regWrite(2'd0, 8'h15);
    regWrite(2'd0, 8'h3C);
    regWrite(2'd0, 8'h3D);
    setPtr();
    regRead(2'd0, v); chk("R4 mode1 readback", v, 8'h15);
    regRead(2'd0, v); chk("R4 mode2 readback", v, 8'h3D);
    regRead(2'd0, v); chk("R4 stays on mode2", v, 8'h3D);
    setMode(8'h00);

    // R2 order sweep
    for (int r = 0; r < 6; r++) begin
      for (int i = 0; i < 3; i++) pushChar(8'((r * 53 + i * 17 + 1) & 255), 0);
      peek(2'd2, v); chk("R2 full flag", v & 3, 3);
      for (int i = 0; i < 3; i++) begin
        regRead(2'd1, v); chk("R2 order", v, (r * 53 + i * 17 + 1) & 255);
      end
      peek(2'd2, v); chk("R2 empty", v & 3, 0);
    end

    // R3 overrun and discard
    for (int i = 0; i < 3; i++) pushChar(8'(10 + i), 0);
    pushChar(8'd99, 0);
    peek(2'd2, v); chk("R3 overrun set", (v >> 2) & 1, 1);
    for (int i = 0; i < 3; i++) begin
      regRead(2'd1, v); chk("R3 discard keeps old", v, 10 + i);
    end
    peek(2'd2, v); chk("R3 empty after drain", v & 1, 0);
    rstErr();
    peek(2'd2, v); chk("R3 overrun cleared", (v >> 2) & 1, 0);
    // R3 simultaneous arrival and removal when full
    for (int i = 0; i < 3; i++) pushChar(8'(20 + i), 0);
    charValid = 1'b1; charData = 8'd23; regRd = 1'b1; regAddr = 2'd1;
    #1 v = readData; chk("R3 same-cycle head", v, 20);
    @(negedge clk);
    charValid = 1'b0; regRd = 1'b0;
    peek(2'd2, v); chk("R3 same-cycle no overrun", v & 7, 3);
    for (int i = 0; i < 3; i++) begin
      regRead(2'd1, v); chk("R3 same-cycle order", v, 21 + i);
    end

    // R5 interrupt source sweep
    for (int sel = 0; sel < 2; sel++) begin
      setMode(8'(sel << 6));
      for (int n = 0; n <= 3; n++) begin
        chk("R5 irq", rxIrq, sel ? (n == 3) : (n > 0));
        if (n < 3) pushChar(8'(n), 0);
      end
      drain();
    end

    // R6 per-character flags
    setMode(8'h00);
    for (int f = 0; f < 8; f++) begin
      pushChar(8'(f), f);
      pushChar(8'(f + 8), 7 - f);
      peek(2'd2, v); chk("R6 head flags", (v >> 3) & 7, f);
      regRead(2'd1, v);
      peek(2'd2, v); chk("R6 next head flags", (v >> 3) & 7, 7 - f);
      regRead(2'd1, v);
      peek(2'd2, v); chk("R6 empty flags", (v >> 3) & 7, 0);
    end

    // R7 accumulating flags
    setMode(8'h20);
    for (int f = 0; f < 8; f++) begin
      int a, b, c;
      a = f; b = (f * 3 + 1) & 7; c = (f * 5 + 2) & 7;
      rstErr();
      pushChar(8'd1, a); pushChar(8'd2, b); pushChar(8'd3, c);
      peek(2'd2, v); chk("R7 first head", (v >> 3) & 7, a);
      regRead(2'd1, v);
      peek(2'd2, v); chk("R7 two", (v >> 3) & 7, a | b);
      regRead(2'd1, v);
      peek(2'd2, v); chk("R7 three", (v >> 3) & 7, a | b | c);
      regRead(2'd1, v);
      peek(2'd2, v); chk("R7 held when empty", (v >> 3) & 7, a | b | c);
      rstErr();
      peek(2'd2, v); chk("R7 cleared", (v >> 3) & 7, 0);
    end

    // R8 software request bit
    setMode(8'h00);
    regWrite(2'd3, 8'h01); chk("R8 asserted", rtsN, 0);
    regWrite(2'd3, 8'h00); chk("R8 negated", rtsN, 1);
    regWrite(2'd3, 8'hFF); chk("R8 asserted again", rtsN, 0);

    // R9 automatic negation
    setMode(8'h80);
    for (int i = 0; i < 3; i++) pushChar(8'(i), 0);
    chk("R9 before start", rtsN, 0);
    pulseStart();
    chk("R9 negated on start", rtsN, 1);
    peek(2'd3, v); chk("R9 sw bit kept", v & 1, 1);
    // R10 release
    regRead(2'd1, v);
    chk("R10 released", rtsN, 0);
    pushChar(8'd7, 0);
    chk("R10 stays asserted refilled", rtsN, 0);
    // R11 no effect cases
    setMode(8'h00);
    pulseStart();
    chk("R11 disabled full", rtsN, 0);
    regRead(2'd1, v);
    setMode(8'h80);
    pulseStart();
    chk("R11 not full", rtsN, 0);
    drain();

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule